// File: doc/BRIEF.md
# Bitmap Video Timing Controller

This block produces the complete raster timing for a monochrome bit-mapped display whose refresh data arrives by processor DMA. All of its timing is counted in processor machine cycles, signalled by a one-clock strobe. Each machine cycle spans eight pixel clocks. A line is fourteen machine cycles long. A frame is 262 lines, and 128 of those lines form the visible window.

On every window line the block requests an eight-cycle DMA-out burst. Each byte that arrives is shifted out serially as video, one pixel per clock, so one line shows 64 pixels. An interrupt request goes out ahead of each window, with fixed spacing, so that software can reload the DMA pointer and stay cycle-locked to the bursts. The block also drives a status flag around the window edges and active-low horizontal, vertical and composite sync. A clear input parks the timebase at the frame origin. A display-enable input stops all requests and blanks the video.

Top module: `bitmap_vtc`

## Requirements
- R1: A line lasts 14 machine cycles and a frame lasts 262 lines. The counters advance only on clocks where the strobe is high. After reset the timebase sits at line 0, machine cycle 0, and every output takes its line-0 value: no requests, black video, status low, horizontal sync high, vertical sync low.
- R2: The DMA request is high during machine cycles 0 to 7 of lines 64 to 191, where line 0 is the first line after the frame origin. It is low at all other times, which gives 128 bursts of 8 cycles in each frame.
- R3: A byte is captured on each clock edge where the strobe and the DMA request are both high. On the following clocks the video output shows that byte most significant bit first, one bit per clock, with 1 meaning white (video high). With no new capture the output shows black (0).
- R4: The interrupt request stays high for exactly 28 consecutive machine cycles in each frame.
- R5: The interrupt request rises exactly 29 machine cycles before the first DMA cycle of the window, which is frame position 867 when position = line*14 + cycle. It is never high together with the DMA request.
- R6: The status flag is high on lines 60 to 63 and on lines 188 to 191, and low on all other lines.
- R7: On every line, horizontal sync is low for 12 pixel clocks. The pulse starts at the first pixel clock of machine cycle 10.
- R8: Vertical sync is low on lines 0 to 15, which lie outside the window. Composite sync is low whenever either horizontal or vertical sync is low.
- R9: While clear is high, the timebase is held at line 0, cycle 0, pixel 0, both requests stay low and video is black. Counting resumes from the origin once clear falls.
- R10: While display enable is low, no DMA or interrupt request is issued and video stays black, and sync and status timing continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mc_stb | input | 1 | One-clock strobe marking the end of each machine cycle |
| clr | input | 1 | Synchronous clear of the timebase, active high |
| disp_en | input | 1 | Display enable; low stops requests and blanks video |
| dbus | input | 8 | DMA data byte from the processor bus |
| dma_req | output | 1 | DMA-out request, one burst per window line |
| int_req | output | 1 | Interrupt request ahead of the window |
| stat_flag | output | 1 | Status flag near the window edges |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| csync_n | output | 1 | Composite sync, active low |
| video | output | 1 | Serial pixel output, 1 = white |

## Verification
Two functions can fall in the same clock. A byte capture at the last DMA cycle of a line coincides with the last pixel of the previous byte. A clear or display-enable change can arrive in the same cycle as a burst or an interrupt. The bench drives clear in the middle of the window, and removes enable for a whole frame and then restores it, all while bursts are running. A cycle-accurate model built from the requirements is compared against every output on every clock. Pulse lengths and the interrupt-to-burst spacing are also measured in clocks and checked against expected values.

// File: rtl/vtc_pkg.sv
// vtc_pkg: default timing constants and a shared span helper for the
// bitmap video timing controller. Assumes eight pixel clocks per machine
// cycle (one per data bit).
package vtc_pkg;
    localparam int LINE_MC_D     = 14;
    localparam int DMA_MC_D      = 8;
    localparam int FRAME_LINES_D = 262;
    localparam int WIN_FIRST_D   = 64;
    localparam int WIN_LINES_D   = 128;
    localparam int INT_LEAD_D    = 29;
    localparam int INT_HOLD_D    = 28;
    localparam int STAT_LINES_D  = 4;
    localparam int HS_START_MC_D = 10;
    localparam int HS_PIX_D      = 12;
    localparam int VS_FIRST_D    = 0;
    localparam int VS_LINES_D    = 16;
    localparam int DATA_W_D      = 8;

    // True when v lies in [lo, lo+n)
    function automatic logic in_span(input logic [31:0] v,
                                     input logic [31:0] lo,
                                     input logic [31:0] n);
        return (v >= lo) && (v < lo + n);
    endfunction
endpackage

// File: rtl/vtc_timebase.sv
// vtc_timebase: pixel, machine-cycle and line counters.
// Assumes mc_stb is high on the last pixel clock of every machine cycle.
// clr or reset parks all counters at the frame origin.
module vtc_timebase #(
    parameter int LINE_MC     = vtc_pkg::LINE_MC_D,
    parameter int FRAME_LINES = vtc_pkg::FRAME_LINES_D,
    parameter int PIX_PER_MC  = vtc_pkg::DATA_W_D,
    localparam int MC_W   = $clog2(LINE_MC),
    localparam int LINE_W = $clog2(FRAME_LINES),
    localparam int PIX_W  = $clog2(PIX_PER_MC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              mc_stb,
    output logic [PIX_W-1:0]  pix_cnt,
    output logic [MC_W-1:0]   mc_cnt,
    output logic [LINE_W-1:0] line_cnt
);
    // Advance pixel, cycle and line positions
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pix_cnt  <= '0;
            mc_cnt   <= '0;
            line_cnt <= '0;
        end else if (mc_stb) begin
            pix_cnt <= '0;
            if (mc_cnt == MC_W'(LINE_MC - 1)) begin
                mc_cnt   <= '0;
                line_cnt <= (line_cnt == LINE_W'(FRAME_LINES - 1)) ? '0 : line_cnt + 1'b1;
            end else begin
                mc_cnt <= mc_cnt + 1'b1;
            end
        end else begin
            pix_cnt <= (pix_cnt == PIX_W'(PIX_PER_MC - 1)) ? '0 : pix_cnt + 1'b1;
        end
    end

    // R1: the last cycle of a line is followed by cycle 0
    a_r1_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (mc_stb && !clr && mc_cnt == MC_W'(LINE_MC - 1)) |=> (mc_cnt == '0));

    // R9: clear returns the timebase to the origin
    a_r9_clear_origin: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (mc_cnt == '0 && line_cnt == '0 && pix_cnt == '0));
endmodule

// File: rtl/vtc_decode.sv
// vtc_decode: turns the timebase position into DMA and interrupt requests,
// the status flag and sync pulses. Purely combinational; requests are
// gated by clear and display enable.
module vtc_decode #(
    parameter int LINE_MC     = vtc_pkg::LINE_MC_D,
    parameter int DMA_MC      = vtc_pkg::DMA_MC_D,
    parameter int FRAME_LINES = vtc_pkg::FRAME_LINES_D,
    parameter int WIN_FIRST   = vtc_pkg::WIN_FIRST_D,
    parameter int WIN_LINES   = vtc_pkg::WIN_LINES_D,
    parameter int INT_LEAD    = vtc_pkg::INT_LEAD_D,
    parameter int INT_HOLD    = vtc_pkg::INT_HOLD_D,
    parameter int STAT_LINES  = vtc_pkg::STAT_LINES_D,
    parameter int HS_START_MC = vtc_pkg::HS_START_MC_D,
    parameter int HS_PIX      = vtc_pkg::HS_PIX_D,
    parameter int VS_FIRST    = vtc_pkg::VS_FIRST_D,
    parameter int VS_LINES    = vtc_pkg::VS_LINES_D,
    parameter int PIX_PER_MC  = vtc_pkg::DATA_W_D,
    localparam int MC_W   = $clog2(LINE_MC),
    localparam int LINE_W = $clog2(FRAME_LINES),
    localparam int PIX_W  = $clog2(PIX_PER_MC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              disp_en,
    input  logic [PIX_W-1:0]  pix_cnt,
    input  logic [MC_W-1:0]   mc_cnt,
    input  logic [LINE_W-1:0] line_cnt,
    output logic              dma_req,
    output logic              int_req,
    output logic              stat_flag,
    output logic              hsync_n,
    output logic              vsync_n
);
    import vtc_pkg::in_span;

    localparam logic [31:0] LMC       = 32'(LINE_MC);
    localparam logic [31:0] PPM       = 32'(PIX_PER_MC);
    localparam logic [31:0] INT_FIRST = 32'(WIN_FIRST * LINE_MC - INT_LEAD);
    localparam logic [31:0] WIN_LAST1 = 32'(WIN_FIRST + WIN_LINES - STAT_LINES);
    localparam logic [31:0] STAT_PRE  = 32'(WIN_FIRST - STAT_LINES);
    localparam logic [31:0] HS_FIRST  = 32'(HS_START_MC * PIX_PER_MC);

    logic [31:0] line_u, mc_u, pos, pidx;
    logic        run;

    // Flatten position into line, frame-cycle and line-pixel indices
    always_comb begin
        line_u = 32'(line_cnt);
        mc_u   = 32'(mc_cnt);
        pos    = line_u * LMC + mc_u;
        pidx   = mc_u * PPM + 32'(pix_cnt);
        run    = disp_en && !clr;
    end

    // Decode requests, status and sync from the position
    always_comb begin
        dma_req   = run && in_span(line_u, 32'(WIN_FIRST), 32'(WIN_LINES))
                        && (mc_u < 32'(DMA_MC));
        int_req   = run && in_span(pos, INT_FIRST, 32'(INT_HOLD));
        stat_flag = in_span(line_u, STAT_PRE, 32'(STAT_LINES))
                 || in_span(line_u, WIN_LAST1, 32'(STAT_LINES));
        hsync_n   = !in_span(pidx, HS_FIRST, 32'(HS_PIX));
        vsync_n   = !in_span(line_u, 32'(VS_FIRST), 32'(VS_LINES));
    end

    // R5: the interrupt never overlaps a burst
    a_r5_int_no_dma: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> !dma_req);

    // R8: vertical sync stays outside the window and status lines
    a_r8_vsync_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_n |-> (!dma_req && !stat_flag));

    // R2: a burst only runs on a cycle that a strobe can end inside the line
    a_r2_dma_early_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> hsync_n);
endmodule

// File: rtl/vtc_shifter.sv
// vtc_shifter: captures one DMA byte and shifts it out MSB first, one bit
// per pixel clock, shifting in black. Video is blanked when disabled.
module vtc_shifter #(
    parameter int DATA_W = vtc_pkg::DATA_W_D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic              disp_en,
    input  logic [DATA_W-1:0] din,
    output logic              video
);
    logic [DATA_W-1:0] sh;

    // Load a new byte or shift the current one left
    always_ff @(posedge clk) begin
        if (!rst_n || clr) sh <= '0;
        else if (load)     sh <= din;
        else               sh <= {sh[DATA_W-2:0], 1'b0};
    end

    // Gate the serial bit with display enable
    assign video = sh[DATA_W-1] && disp_en;

    // R3: the most significant bit of a captured byte shows first
    a_r3_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr) |=> (sh[DATA_W-1] == $past(din[DATA_W-1])));
endmodule

// File: rtl/bitmap_vtc.sv
// bitmap_vtc: top of the bitmap video timing controller. Assumes one
// machine cycle equals DATA_W pixel clocks, marked by mc_stb.
module bitmap_vtc #(
    parameter int LINE_MC     = vtc_pkg::LINE_MC_D,
    parameter int FRAME_LINES = vtc_pkg::FRAME_LINES_D,
    parameter int DATA_W      = vtc_pkg::DATA_W_D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_stb,
    input  logic              clr,
    input  logic              disp_en,
    input  logic [DATA_W-1:0] dbus,
    output logic              dma_req,
    output logic              int_req,
    output logic              stat_flag,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              csync_n,
    output logic              video
);
    localparam int MC_W   = $clog2(LINE_MC);
    localparam int LINE_W = $clog2(FRAME_LINES);
    localparam int PIX_W  = $clog2(DATA_W);

    logic [PIX_W-1:0]  pix_cnt;
    logic [MC_W-1:0]   mc_cnt;
    logic [LINE_W-1:0] line_cnt;

    vtc_timebase #(.LINE_MC(LINE_MC), .FRAME_LINES(FRAME_LINES), .PIX_PER_MC(DATA_W))
    u_tb (.clk(clk), .rst_n(rst_n), .clr(clr), .mc_stb(mc_stb),
          .pix_cnt(pix_cnt), .mc_cnt(mc_cnt), .line_cnt(line_cnt));

    vtc_decode #(.LINE_MC(LINE_MC), .FRAME_LINES(FRAME_LINES), .PIX_PER_MC(DATA_W))
    u_dec (.clk(clk), .rst_n(rst_n), .clr(clr), .disp_en(disp_en),
           .pix_cnt(pix_cnt), .mc_cnt(mc_cnt), .line_cnt(line_cnt),
           .dma_req(dma_req), .int_req(int_req), .stat_flag(stat_flag),
           .hsync_n(hsync_n), .vsync_n(vsync_n));

    vtc_shifter #(.DATA_W(DATA_W))
    u_sh (.clk(clk), .rst_n(rst_n), .clr(clr), .load(dma_req && mc_stb),
          .disp_en(disp_en), .din(dbus), .video(video));

    // Combine both sync pulses into one active-low composite
    assign csync_n = hsync_n && vsync_n;
endmodule

// File: tb/test_bitmap_vtc.sv
module test_bitmap_vtc;
    localparam int CLK_PERIOD = 10;
    localparam int FRAME_MC   = 262 * 14;

    logic clk = 0, rst_n = 0, mc_stb = 0, clr = 0, disp_en = 1;
    logic [7:0] dbus = 0;
    logic dma_req, int_req, stat_flag, hsync_n, vsync_n, csync_n, video;

    bitmap_vtc i_bitmap_vtc (.clk(clk), .rst_n(rst_n), .mc_stb(mc_stb), .clr(clr),
        .disp_en(disp_en), .dbus(dbus), .dma_req(dma_req), .int_req(int_req),
        .stat_flag(stat_flag), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .csync_n(csync_n), .video(video));

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0;
    int epos = 0, epix = 0, gcnt = 0;
    logic [7:0] evb = 0;
    int n_dma, n_int, n_hs, n_vs, n_int_rise, int_to_dma, since_int, int_gap, since_prev;
    logic p_int = 0, p_dma = 0, gap_bad = 0, armed = 0;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic span(input int v, input int lo, input int n);
        return v >= lo && v < lo + n;
    endfunction
    function automatic logic e_dma(input int p);
        return disp_en && !clr && span(p / 14, 64, 128) && (p % 14) < 8;
    endfunction

    // One pixel clock: update model, compare all outputs, drive next inputs
    task automatic step();
        int ln, mc;
        logic edma, eint, estat, ehs, evs;
        @(negedge clk);
        if (!rst_n || clr) begin
            epos = 0; epix = 0; evb = 0;
        end else begin
            if (mc_stb && e_dma(epos)) evb = dbus;
            else evb = {evb[6:0], 1'b0};
            if (mc_stb) begin epos = (epos + 1) % FRAME_MC; epix = 0; end
            else epix = (epix + 1) % 8;
        end
        ln = epos / 14; mc = epos % 14;
        edma  = e_dma(epos);
        eint  = disp_en && !clr && span(epos, 867, 28);
        estat = span(ln, 60, 4) || span(ln, 188, 4);
        ehs   = !span(mc * 8 + epix, 80, 12);
        evs   = !span(ln, 0, 16);
        chk(dma_req === edma, "R2 dma_req", dma_req, edma);
        chk(int_req === eint, "R4/R5 int_req", int_req, eint);
        chk(stat_flag === estat, "R6 stat_flag", stat_flag, estat);
        chk(hsync_n === ehs, "R7 hsync_n", hsync_n, ehs);
        chk(vsync_n === evs, "R8 vsync_n", vsync_n, evs);
        chk(csync_n === (ehs && evs), "R8 csync_n", csync_n, ehs && evs);
        chk(video === (evb[7] && disp_en), "R3 video", video, evb[7] && disp_en);
        // measurements
        n_dma += dma_req; n_int += int_req; n_hs += !hsync_n; n_vs += !vsync_n;
        since_int++; since_prev++;
        if (int_req && !p_int) begin
            n_int_rise++; since_int = 0;
            if (armed && since_prev != FRAME_MC * 8) gap_bad = 1;
            armed = 1; since_prev = 0;
        end
        if (dma_req && !p_dma && int_to_dma < 0) int_to_dma = since_int;
        p_int = int_req; p_dma = dma_req;
        mc_stb = (gcnt == 7);
        gcnt = (gcnt + 1) % 8;
        dbus = 8'(epos * 29 + gcnt * 7 + 3);
    endtask

    task automatic clr_meas();
        n_dma = 0; n_int = 0; n_hs = 0; n_vs = 0; n_int_rise = 0;
        int_to_dma = -1; since_int = 0;
    endtask

    task automatic t_reset();
        rst_n = 0; gcnt = 0; mc_stb = 0;
        repeat (4) step();
        rst_n = 1;
        // R1: reset state
        chk(!dma_req && !int_req && !video, "R1 reset requests/video", {dma_req, int_req, video}, 0);
        chk(hsync_n && !vsync_n && !stat_flag, "R1 reset sync/status",
            {hsync_n, vsync_n, stat_flag}, 3'b100);
    endtask

    task automatic t_sweep();
        clr_meas(); armed = 0; gap_bad = 0;
        repeat (2 * FRAME_MC * 8) step();
        chk(n_dma == 2 * 128 * 64, "R2 dma clocks", n_dma, 2 * 128 * 64);
        chk(n_int == 2 * 28 * 8, "R4 int clocks", n_int, 2 * 28 * 8);
        chk(n_int_rise == 2, "R1 one interrupt per frame", n_int_rise, 2);
        chk(!gap_bad, "R1 frame length 3668 cycles", gap_bad, 0);
        chk(int_to_dma == 29 * 8, "R5 int to first dma", int_to_dma, 29 * 8);
        chk(n_hs == 2 * 262 * 12, "R7 hsync clocks", n_hs, 2 * 262 * 12);
        chk(n_vs == 2 * 16 * 112, "R8 vsync clocks", n_vs, 2 * 16 * 112);
    endtask

    task automatic t_clear();
        while (epos != 71 * 14 + 3) step();
        clr = 1;
        repeat (40) begin
            step();
            chk(!dma_req && !int_req && !video, "R9 clear suppresses",
                {dma_req, int_req, video}, 0);
        end
        clr = 0;
        step();
        chk(!vsync_n, "R9 restart at line 0", vsync_n, 0);
        clr_meas();
        repeat (200 * 112) step();
        chk(int_to_dma == 29 * 8, "R9 spacing after clear", int_to_dma, 29 * 8);
    endtask

    task automatic t_disable();
        disp_en = 0; clr_meas();
        repeat (FRAME_MC * 8) begin
            step();
            chk(!dma_req && !int_req && !video, "R10 disabled quiet",
                {dma_req, int_req, video}, 0);
        end
        chk(n_hs == 262 * 12, "R10 hsync continues", n_hs, 262 * 12);
        disp_en = 1; clr_meas();
        repeat (200 * 112) step();
        chk(n_dma > 0, "R10 bursts resume", n_dma, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 195000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_sweep();
        t_clear();
        t_disable();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule